// File: doc/BRIEF.md
# Lockable Page Translation Buffer

This block turns a 32-bit virtual address into a 32-bit physical address for a small embedded RISC core. Addresses are handled in 4 KB pages. The low twelve offset bits pass straight through. The upper twenty bits, the page number, are translated through a fully associative table of 64 entries. Any translation may sit in any entry. Each entry holds a page number, a 6-bit address-space tag, a 20-bit physical frame number and four flags: valid, dirty, global and no-cache.

Two kernel address windows never use the table. Kernel addresses from 0x8000_0000 to 0x9FFF_FFFF and from 0xA000_0000 to 0xBFFF_FFFF become physical addresses by clearing their top three bits. The second window is reported as uncached. User-mode accesses to the upper half of the address space are refused with an address-error fault. Kernel addresses from 0xC000_0000 upward and all user addresses below 0x8000_0000 are translated through the table.

Privileged software fills the table through a write port. It names either an explicit index or the current replacement index. The replacement index is a free-running counter that only covers entries 8 to 63. Entries 0 to 7 therefore stay in place until software rewrites them by explicit index.

Top module: `addr_xlat`

## Requirements
- R1: After reset every entry is cleared, including its valid flag, and `victim_index` reads 63. A user lookup of address 0x0000_0000 with tag 0 therefore reports status 2 (invalid).
- R2: A kernel lookup in 0x8000_0000..0x9FFF_FFFF reports status 0 (hit), with `lk_paddr` equal to the address with bits 31..29 cleared and `lk_uncached` low. This holds for loads and stores alike.
- R3: A kernel lookup in 0xA000_0000..0xBFFF_FFFF reports status 0, with `lk_paddr` equal to the address with bits 31..29 cleared and `lk_uncached` high.
- R4: A user lookup with address bit 31 set reports status 4 (address error), and `lk_paddr` is 0.
- R5: A mapped lookup that hits a valid entry reports status 0 and drives `lk_paddr` = {frame number, vaddr[11:0]}. It drives `lk_uncached` from the entry's no-cache flag.
- R6: An entry matches when its page number equals vaddr[31:12] and either its tag equals `lk_asid` or its global flag is set. When no entry matches, the status is 1 (miss) and `lk_paddr` is 0.
- R7: When the matching entry's valid flag is clear, the status is 2 (invalid) and `lk_paddr` is 0.
- R8: A store that hits a valid entry whose dirty flag is clear reports status 3 (modify fault) with `lk_paddr` 0. A load of the same entry reports status 0.
- R9: `victim_index` advances by one on every clock after reset, and wraps from 63 back to 8.
- R10: `victim_index` never names one of the locked entries 0..7.
- R11: A write lands at the clock edge. It goes to `wr_index`, or to the `victim_index` shown in that cycle when `wr_use_victim` is high. A lookup in the same cycle still sees the old contents.
- R12: When several entries match, the lowest-numbered entry decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_store | input | 1 | 1 = store access, 0 = load access |
| lk_asid | input | 6 | Address-space tag of the current process |
| lk_paddr | output | 32 | Physical address; 0 unless the status is hit |
| lk_status | output | 3 | 0 hit, 1 miss, 2 invalid, 3 modify fault, 4 address error |
| lk_uncached | output | 1 | Access must bypass caches |
| wr_en | input | 1 | Write an entry at the next clock edge |
| wr_use_victim | input | 1 | Write to the replacement index instead of `wr_index` |
| wr_index | input | 6 | Explicit entry index for a write |
| wr_vpn | input | 20 | Page number to store |
| wr_asid | input | 6 | Address-space tag to store |
| wr_pfn | input | 20 | Physical frame number to store |
| wr_valid | input | 1 | Valid flag to store |
| wr_dirty | input | 1 | Dirty (writable) flag to store |
| wr_global | input | 1 | Global flag to store |
| wr_nocache | input | 1 | No-cache flag to store |
| victim_index | output | 6 | Current replacement index |

## Verification
A table write and a lookup of the very page being written can fall in the same cycle. To provoke this, the bench drives both during one low clock phase. It expects the old answer (a miss) before the edge and the new translation after it. The replacement counter also steps on the same edge that consumes it for a victim write. The bench records the index its own counter model predicts for that cycle. It then overwrites that index by explicit address, and a lookup of the first page now missing shows that the victim write landed at the predicted index and not at the next one.

// File: rtl/xlat_pkg.sv
// Shared widths, entry layout and result codes for the page translation buffer.
// Assumes 32-bit addresses and 4 KB pages.
package xlat_pkg;
    localparam int VA_W   = 32;
    localparam int OFS_W  = 12;
    localparam int VPN_W  = VA_W - OFS_W;
    localparam int PFN_W  = 20;
    localparam int ASID_W = 6;

    typedef enum logic [2:0] {
        XS_HIT     = 3'd0,
        XS_MISS    = 3'd1,
        XS_INVALID = 3'd2,
        XS_MODIFY  = 3'd3,
        XS_ADDRERR = 3'd4
    } xlat_status_e;

    typedef enum logic [1:0] {
        SEG_MAPPED   = 2'd0,
        SEG_DIRECT_C = 2'd1,
        SEG_DIRECT_U = 2'd2,
        SEG_FAULT    = 2'd3
    } seg_kind_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        logic              valid;
        logic              dirty;
        logic              global_map;
        logic              nocache;
    } xlat_entry_t;
endpackage

// File: rtl/xlat_segment.sv
// Classifies an address by its top three bits and the privilege mode.
// Assumes: user mode may only touch the lower half of the address space;
// the two kernel windows 100 and 101 are direct-mapped (cached, uncached).
module xlat_segment
    import xlat_pkg::*;
(
    input  logic [2:0] top_bits,
    input  logic       user_mode,
    output seg_kind_e  kind
);
    // Decode the segment kind from the address top bits and mode.
    always_comb begin
        if (user_mode && top_bits[2])       kind = SEG_FAULT;
        else if (top_bits == 3'b100)        kind = SEG_DIRECT_C;
        else if (top_bits == 3'b101)        kind = SEG_DIRECT_U;
        else                                kind = SEG_MAPPED;
    end
endmodule

// File: rtl/xlat_victim.sv
// Free-running replacement pointer that skips the locked low entries.
// Assumes LOCKED < ENTRIES; a reset parks the pointer on the top entry.
module xlat_victim #(
    parameter int ENTRIES = 64,
    parameter int LOCKED  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] victim
);
    localparam logic [IDX_W-1:0] TOP   = IDX_W'(ENTRIES - 1);
    localparam logic [IDX_W-1:0] FLOOR = IDX_W'(LOCKED);

    // Step the pointer every cycle, wrapping from the top to the first unlocked entry.
    always_ff @(posedge clk) begin
        if (!rst_n)            victim <= TOP;
        else if (victim == TOP) victim <= FLOOR;
        else                   victim <= victim + 1'b1;
    end
endmodule

// File: rtl/xlat_cam.sv
// Entry storage with a parallel tag compare and a lowest-index-wins select.
// Assumes one write per cycle; lookups are purely combinational on stored state.
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  xlat_entry_t       wr_entry,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              any_match,
    output xlat_entry_t       sel_entry
);
    xlat_entry_t        tbl_q [ENTRIES];
    logic [ENTRIES-1:0] match;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // Hold one entry; clear on reset, load when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                               tbl_q[e] <= '0;
            else if (wr_en && wr_idx == IDX_W'(e))    tbl_q[e] <= wr_entry;
        end

        // Compare page number, and tag unless the entry is global.
        assign match[e] = (tbl_q[e].vpn == lk_vpn) &&
                          (tbl_q[e].global_map || tbl_q[e].asid == lk_asid);
    end

    // Pick the lowest matching entry by scanning from the top down.
    always_comb begin
        sel_entry = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) sel_entry = tbl_q[i];
        end
    end

    assign any_match = |match;
endmodule

// File: rtl/addr_xlat.sv
// Top of the page translation buffer: segment decode, associative lookup,
// protection result and lock-aware fill. Lookup is combinational; writes land
// at the clock edge. Assumes LOCKED low entries are reserved for software.
module addr_xlat
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int LOCKED  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_user,
    input  logic              lk_store,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [VA_W-1:0]   lk_paddr,
    output logic [2:0]        lk_status,
    output logic              lk_uncached,
    input  logic              wr_en,
    input  logic              wr_use_victim,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic              wr_global,
    input  logic              wr_nocache,
    output logic [IDX_W-1:0]  victim_index
);
    seg_kind_e        kind;
    logic             any_match;
    xlat_entry_t      hit_e;
    xlat_entry_t      new_e;
    logic [IDX_W-1:0] target;
    xlat_status_e     status;

    xlat_segment u_seg (
        .top_bits  (lk_vaddr[VA_W-1:VA_W-3]),
        .user_mode (lk_user),
        .kind      (kind)
    );

    xlat_victim #(.ENTRIES(ENTRIES), .LOCKED(LOCKED)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .victim (victim_index)
    );

    // Assemble the entry to store and choose where it goes.
    always_comb begin
        new_e.vpn        = wr_vpn;
        new_e.asid       = wr_asid;
        new_e.pfn        = wr_pfn;
        new_e.valid      = wr_valid;
        new_e.dirty      = wr_dirty;
        new_e.global_map = wr_global;
        new_e.nocache    = wr_nocache;
        target           = wr_use_victim ? victim_index : wr_index;
    end

    xlat_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (target),
        .wr_entry  (new_e),
        .lk_vpn    (lk_vaddr[VA_W-1:OFS_W]),
        .lk_asid   (lk_asid),
        .any_match (any_match),
        .sel_entry (hit_e)
    );

    // Form the result: direct windows, faults, then table outcomes in priority order.
    always_comb begin
        lk_paddr    = '0;
        lk_uncached = 1'b0;
        status      = XS_HIT;
        unique case (kind)
            SEG_FAULT: status = XS_ADDRERR;
            SEG_DIRECT_C, SEG_DIRECT_U: begin
                lk_paddr    = {3'b000, lk_vaddr[VA_W-4:0]};
                lk_uncached = (kind == SEG_DIRECT_U);
            end
            default: begin
                if (!any_match)                  status = XS_MISS;
                else if (!hit_e.valid)           status = XS_INVALID;
                else if (lk_store && !hit_e.dirty) status = XS_MODIFY;
                else begin
                    lk_paddr    = {hit_e.pfn, lk_vaddr[OFS_W-1:0]};
                    lk_uncached = hit_e.nocache;
                end
            end
        endcase
    end

    assign lk_status = status;
endmodule

// File: rtl/addr_xlat_checker.sv
// Temporal checks on the translation buffer ports, bound into every instance.
module addr_xlat_checker #(
    parameter int ENTRIES = 64,
    parameter int LOCKED  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      lk_vaddr,
    input logic             lk_user,
    input logic [31:0]      lk_paddr,
    input logic [2:0]       lk_status,
    input logic             lk_uncached,
    input logic [IDX_W-1:0] victim_index
);
    // R9: the pointer steps by one and wraps to the first unlocked entry
    a_r9_victim_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> victim_index == (($past(victim_index) == IDX_W'(ENTRIES - 1)) ?
                                   IDX_W'(LOCKED) : $past(victim_index) + 1'b1));

    // R10: locked entries are never offered for replacement
    a_r10_victim_floor: assert property (@(posedge clk) disable iff (!rst_n)
        victim_index >= IDX_W'(LOCKED));

    // R4: user access to the upper half faults with no address
    a_r4_user_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_user && lk_vaddr[31]) |-> (lk_status == 3'd4 && lk_paddr == 32'd0));

    // R2 / R3: kernel direct windows strip the top three bits
    a_r2_direct_map: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_user && lk_vaddr[31:30] == 2'b10) |->
        (lk_status == 3'd0 && lk_paddr == {3'b000, lk_vaddr[28:0]} &&
         lk_uncached == lk_vaddr[29]));

    // R5: a hit always keeps the page offset
    a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_status == 3'd0) |-> (lk_paddr[11:0] == lk_vaddr[11:0]));

    // R6 / R7 / R8: any non-hit outcome drives a zero address
    a_r6_nohit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_status != 3'd0) |-> (lk_paddr == 32'd0 && !lk_uncached));
endmodule

bind addr_xlat addr_xlat_checker #(.ENTRIES(ENTRIES), .LOCKED(LOCKED)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_vaddr     (lk_vaddr),
    .lk_user      (lk_user),
    .lk_paddr     (lk_paddr),
    .lk_status    (lk_status),
    .lk_uncached  (lk_uncached),
    .victim_index (victim_index)
);

// File: tb/addr_xlat_test.sv
module addr_xlat_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_user = 1'b0, lk_store = 1'b0;
    logic [5:0]  lk_asid = '0;
    logic [31:0] lk_paddr;
    logic [2:0]  lk_status;
    logic        lk_uncached;
    logic        wr_en = 1'b0, wr_use_victim = 1'b0;
    logic [5:0]  wr_index = '0;
    logic [19:0] wr_vpn = '0, wr_pfn = '0;
    logic [5:0]  wr_asid = '0;
    logic        wr_valid = 1'b0, wr_dirty = 1'b0, wr_global = 1'b0, wr_nocache = 1'b0;
    logic [5:0]  victim_index;

    int checks = 0, errors = 0, cycles = 0;
    logic [5:0] model_v;

    always #10 clk = ~clk;

    addr_xlat uut (.*);

    // Independent model of the replacement pointer (R9).
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n)             model_v <= 6'd63;
        else if (model_v == 63) model_v <= 6'd8;
        else                    model_v <= model_v + 6'd1;
    end

    typedef struct packed {
        logic user; logic store; logic [5:0] asid; logic [31:0] va;
        logic [2:0] st; logic [31:0] pa; logic unc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 6'd5, 32'h0040_0ABC, 3'd0, 32'h1234_5ABC, 1'b0}, // R5 R12
        '{1'b1, 1'b1, 6'd5, 32'h0040_0ABC, 3'd0, 32'h1234_5ABC, 1'b0}, // R8 dirty store
        '{1'b1, 1'b0, 6'd7, 32'h0040_1123, 3'd0, 32'hABCD_E123, 1'b1}, // R6 global
        '{1'b1, 1'b1, 6'd7, 32'h0040_1123, 3'd3, 32'h0000_0000, 1'b0}, // R8 modify
        '{1'b1, 1'b0, 6'd6, 32'h0040_0ABC, 3'd1, 32'h0000_0000, 1'b0}, // R6 tag mismatch
        '{1'b1, 1'b0, 6'd5, 32'h0040_2000, 3'd2, 32'h0000_0000, 1'b0}, // R7
        '{1'b1, 1'b0, 6'd5, 32'h1234_5678, 3'd1, 32'h0000_0000, 1'b0}, // R6 miss
        '{1'b0, 1'b0, 6'd5, 32'h8123_4567, 3'd0, 32'h0123_4567, 1'b0}, // R2
        '{1'b0, 1'b1, 6'd5, 32'h9FFF_FFFF, 3'd0, 32'h1FFF_FFFF, 1'b0}, // R2 store
        '{1'b0, 1'b0, 6'd5, 32'hA000_0010, 3'd0, 32'h0000_0010, 1'b1}, // R3
        '{1'b0, 1'b0, 6'd5, 32'hC000_0444, 3'd0, 32'h2222_2444, 1'b0}, // R5 kernel mapped
        '{1'b1, 1'b0, 6'd5, 32'hC000_0444, 3'd4, 32'h0000_0000, 1'b0}, // R4
        '{1'b1, 1'b0, 6'd5, 32'h8000_0000, 3'd4, 32'h0000_0000, 1'b0}, // R4
        '{1'b0, 1'b0, 6'd5, 32'h7FFF_F000, 3'd1, 32'h0000_0000, 1'b0}  // R6 kernel miss
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic look(input logic u, input logic s, input logic [5:0] a, input logic [31:0] va);
        lk_user = u; lk_store = s; lk_asid = a; lk_vaddr = va;
        #5;
    endtask

    task automatic put(input logic vic, input logic [5:0] idx, input logic [19:0] vpn,
                       input logic [5:0] asid, input logic [19:0] pfn,
                       input logic v, input logic d, input logic g, input logic nc);
        wr_en = 1'b1; wr_use_victim = vic; wr_index = idx; wr_vpn = vpn; wr_asid = asid;
        wr_pfn = pfn; wr_valid = v; wr_dirty = d; wr_global = g; wr_nocache = nc;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_use_victim = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: an overlong run counts as a failed check.
    initial begin
        wait (cycles > 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
        finish_run();
    end

    initial begin
        logic [5:0] vslot;
        repeat (3) @(negedge clk);
        // R1: reset state before release
        check("R1 victim", 64'(victim_index), 64'd63);
        rst_n = 1'b1;
        look(1'b1, 1'b0, 6'd0, 32'h0000_0000);
        check("R1 cleared", 64'(lk_status), 64'd2);
        @(negedge clk);

        // Fill entries by explicit index.
        put(1'b0, 6'd0, 20'h00400, 6'd5, 20'h12345, 1'b1, 1'b1, 1'b0, 1'b0);
        put(1'b0, 6'd1, 20'h00401, 6'd0, 20'hABCDE, 1'b1, 1'b0, 1'b1, 1'b1);
        put(1'b0, 6'd2, 20'h00402, 6'd5, 20'h11111, 1'b0, 1'b1, 1'b0, 1'b0);
        put(1'b0, 6'd3, 20'hC0000, 6'd5, 20'h22222, 1'b1, 1'b1, 1'b0, 1'b0);
        put(1'b0, 6'd4, 20'h00400, 6'd5, 20'h33333, 1'b1, 1'b1, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            look(VEC[i].user, VEC[i].store, VEC[i].asid, VEC[i].va);
            check($sformatf("vector %0d status", i), 64'(lk_status), 64'(VEC[i].st));
            check($sformatf("vector %0d paddr", i), 64'(lk_paddr), 64'(VEC[i].pa));
            check($sformatf("vector %0d uncached", i), 64'(lk_uncached), 64'(VEC[i].unc));
            @(negedge clk);
        end

        // R9 R10: pointer follows the model across a full wrap
        for (int i = 0; i < 70; i++) begin
            check("R9 victim step", 64'(victim_index), 64'(model_v));
            checks++;
            if (victim_index < 6'd8) begin
                errors++;
                $display("FAIL R10: actual %0d expected >= 8", victim_index);
            end
            @(negedge clk);
        end

        // R11: victim write and same-cycle lookup of the same page
        vslot = model_v;
        wr_en = 1'b1; wr_use_victim = 1'b1; wr_index = 6'd0; wr_vpn = 20'h55555;
        wr_asid = 6'd5; wr_pfn = 20'h44444; wr_valid = 1'b1; wr_dirty = 1'b1;
        wr_global = 1'b0; wr_nocache = 1'b0;
        look(1'b1, 1'b0, 6'd5, 32'h5555_5ABC);
        check("R11 old contents same cycle", 64'(lk_status), 64'd1);
        @(posedge clk); #1;
        wr_en = 1'b0; wr_use_victim = 1'b0;
        @(negedge clk);
        look(1'b1, 1'b0, 6'd5, 32'h5555_5ABC);
        check("R11 new status", 64'(lk_status), 64'd0);
        check("R11 new paddr", 64'(lk_paddr), 64'h4444_4ABC);
        @(negedge clk);
        // Overwrite the predicted slot; the page must vanish if it landed there.
        put(1'b0, vslot, 20'h66666, 6'd5, 20'h77777, 1'b1, 1'b1, 1'b0, 1'b0);
        look(1'b1, 1'b0, 6'd5, 32'h5555_5ABC);
        check("R11 victim slot", 64'(lk_status), 64'd1);
        look(1'b1, 1'b0, 6'd5, 32'h6666_6001);
        check("R11 explicit slot", 64'(lk_paddr), 64'h7777_7001);
        @(negedge clk);

        // R12: invalidate entry 0; entry 4 still matches but entry 0 wins
        put(1'b0, 6'd0, 20'h00400, 6'd5, 20'h12345, 1'b0, 1'b1, 1'b0, 1'b0);
        look(1'b1, 1'b0, 6'd5, 32'h0040_0ABC);
        check("R12 lowest wins", 64'(lk_status), 64'd2);
        check("R7 invalid paddr", 64'(lk_paddr), 64'd0);
        @(negedge clk);

        // R1: reset again clears the table
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 victim after reset", 64'(victim_index), 64'd63);
        rst_n = 1'b1;
        look(1'b0, 1'b0, 6'd5, 32'hC000_0444);
        check("R1 entry cleared", 64'(lk_status), 64'd1);
        @(negedge clk);

        finish_run();
    end
endmodule